// File: doc/BRIEF.md
# Vector Lane Conflict Detector

This block takes a vector of sixteen 32-bit elements, usually the addresses or indices that a scatter is about to write, and reports for each element which lower-numbered elements hold the same value. Each lane's answer is a 16-bit bitmap. It is placed zero-extended in that lane's 32-bit slot of the result vector. A scatter engine or software loop can then see duplicates before committing writes, and can order or merge them.

A zero-masking mode uses a 16-bit lane select to choose which result slots are filled. Unselected slots read as zero. The select only gates the outputs: every lane is still compared against every lower lane, whether or not that lower lane is selected. A caller that wants a lane left out of the comparisons must replace its value with one that occurs nowhere else in the vector. All comparisons happen in one cycle and the result is registered, so a result appears one cycle after the input is accepted.

Top module: `lconf_detect`

## Requirements
- R1: Bit j of result lane i is 1 exactly when j < i and input lane j equals input lane i in all 32 bits. For inputs 1,1,1,2 in lanes 0..3, lanes 1, 2 and 3 give 0x1, 0x3 and 0x0.
- R2: In result lane i, bits i through 31 are always 0. This includes bits 16..31 of every lane.
- R3: Result lane 0 is always zero.
- R4: When `in_zmask` is 1, every lane whose `in_mask` bit is 0 produces an all-zero result slot.
- R5: When `in_zmask` is 0, `in_mask` has no effect and all sixteen lanes carry their bitmap.
- R6: The mask never shrinks the comparison set. A selected lane still reports matches against lower lanes whose mask bit is 0.
- R7: `out_valid` equals `in_valid` delayed by one clock. A result produced from inputs accepted at one edge is visible after the next edge.
- R8: While `rst` is high, `out_valid` and `out_vec` are cleared to 0 at each clock edge.
- R9: A cycle with `in_valid` low leaves `out_vec` unchanged, whatever the other inputs do.
- R10: A vector of sixteen equal values gives lane i the value 2^i−1. A vector of sixteen distinct values gives all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input vector is valid this cycle |
| in_vec | input | 512 | Sixteen 32-bit elements; lane k occupies bits 32k+31..32k |
| in_mask | input | 16 | Lane select; bit k selects lane k |
| in_zmask | input | 1 | 1 = apply zero-masking with in_mask, 0 = fill all lanes |
| out_valid | output | 1 | Result vector is valid |
| out_vec | output | 512 | Sixteen 32-bit results; lane k occupies bits 32k+31..32k |

## Verification
The assertions check the following on every clock cycle:
- Each of the 120 result bits against the equality of the registered input pair, covering match reporting and the comparison set under masking.
- Zero upper bits in every result slot and an always-zero lane 0.
- Zeroed unselected lanes in zero-masking mode.
- One-cycle valid latency, output hold while idle, and clearing on reset.

Only the bench's scenarios can show the following:
- The mask being ignored when zero-masking is off, shown by comparing whole vectors with a model.
- The whole-vector patterns: the 1,1,1,2 example, all-equal and all-distinct vectors, and values that differ only in the top or bottom bit.
- Collision-rich random vectors checked against the model.

// File: rtl/lconf_pkg.sv
package lconf_pkg;

  typedef enum logic {
    FILL_ALL  = 1'b0,
    FILL_SEL  = 1'b1
  } fill_mode_e;

  // population-free helper: index of lane slice start
  function automatic int unsigned slice_lo(input int unsigned lane, input int unsigned w);
    return lane * w;
  endfunction

endpackage

// File: rtl/lconf_eq_matrix.sv
module lconf_eq_matrix #(
  parameter int unsigned LANES = 16,
  parameter int unsigned DW    = 32
) (
  input  logic [LANES*DW-1:0]    vec,
  output logic [LANES*LANES-1:0] hit
);
  // hit[i*LANES + j] : lane j (j < i) equals lane i
  for (genvar i = 0; i < LANES; i++) begin : g_row
    for (genvar j = 0; j < LANES; j++) begin : g_col
      if (j < i) begin : g_cmp
        assign hit[i*LANES + j] = (vec[i*DW +: DW] == vec[j*DW +: DW]);
      end else begin : g_none
        assign hit[i*LANES + j] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/lconf_lane_gate.sv
module lconf_lane_gate
  import lconf_pkg::*;
#(
  parameter int unsigned LANES = 16,
  parameter int unsigned DW    = 32
) (
  input  logic [LANES*LANES-1:0] hit,
  input  logic [LANES-1:0]       sel,
  input  fill_mode_e             mode,
  output logic [LANES*DW-1:0]    res
);
  localparam int unsigned PAD = DW - LANES;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic keep;
    assign keep = (mode == FILL_ALL) || sel[i];
    if (PAD > 0) begin : g_pad
      assign res[i*DW +: DW] = keep ? {{PAD{1'b0}}, hit[i*LANES +: LANES]} : '0;
    end else begin : g_nopad
      assign res[i*DW +: DW] = keep ? hit[i*LANES +: DW] : '0;
    end
  end

endmodule

// File: rtl/lconf_out_reg.sv
module lconf_out_reg #(
  parameter int unsigned W = 512
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= d_valid;
      if (d_valid) q <= d;
    end
  end

  // R7
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q_valid == $past(d_valid)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !d_valid |=> $stable(q));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!q_valid && q == '0));

endmodule

// File: rtl/lconf_detect.sv
module lconf_detect
  import lconf_pkg::*;
#(
  parameter int unsigned LANES = 16,
  parameter int unsigned DW    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [LANES*DW-1:0] in_vec,
  input  logic [LANES-1:0]    in_mask,
  input  logic                in_zmask,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_vec
);
  localparam int unsigned VW = LANES * DW;
  localparam int unsigned HW = LANES * LANES;

  logic [HW-1:0] hit;
  logic [VW-1:0] gated;
  fill_mode_e    mode;

  assign mode = in_zmask ? FILL_SEL : FILL_ALL;

  lconf_eq_matrix #(.LANES(LANES), .DW(DW)) i_matrix (
    .vec (in_vec),
    .hit (hit)
  );

  lconf_lane_gate #(.LANES(LANES), .DW(DW)) i_gate (
    .hit  (hit),
    .sel  (in_mask),
    .mode (mode),
    .res  (gated)
  );

  lconf_out_reg #(.W(VW)) i_oreg (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d       (gated),
    .q_valid (out_valid),
    .q       (out_vec)
  );

  // R3
  lane0_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_vec[DW-1:0] == '0);

  for (genvar i = 1; i < LANES; i++) begin : g_chk
    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
      out_vec[i*DW + i +: DW - i] == '0);

    // R4
    masked_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_zmask && !in_mask[i]) |=> (out_vec[i*DW +: DW] == '0));

    for (genvar j = 0; j < i; j++) begin : g_pair
      // R1 and R6: mask state of lane j does not matter
      pair_match_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (!in_zmask || in_mask[i])) |=>
          (out_vec[i*DW + j] == $past(in_vec[i*DW +: DW] == in_vec[j*DW +: DW])));
    end
  end

endmodule

// File: tb/test_lconf_detect.sv
`timescale 1ns/1ps
module test_lconf_detect;
  localparam int unsigned LANES = 16;
  localparam int unsigned DW    = 32;
  localparam int unsigned VW    = LANES * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [VW-1:0] in_vec = '0;
  logic [15:0]   in_mask = '0;
  logic          in_zmask = 1'b0;
  logic          out_valid;
  logic [VW-1:0] out_vec;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lconf_detect #(.LANES(LANES), .DW(DW)) i_lconf_detect (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
    .in_mask(in_mask), .in_zmask(in_zmask),
    .out_valid(out_valid), .out_vec(out_vec)
  );

  function automatic logic [VW-1:0] model(input logic [VW-1:0] v,
                                          input logic [15:0] m, input logic zm);
    logic [VW-1:0] r = '0;
    for (int i = 0; i < LANES; i++) begin
      for (int j = 0; j < i; j++)
        if (v[i*DW +: DW] == v[j*DW +: DW]) r[i*DW + j] = 1'b1;
      if (zm && !m[i]) r[i*DW +: DW] = '0;
    end
    return r;
  endfunction

  task automatic chk(input logic [VW-1:0] act, input logic [VW-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // drive at negedge, result registered at next posedge, sampled at following negedge
  task automatic apply(input logic [VW-1:0] v, input logic [15:0] m,
                       input logic zm, input string req);
    in_vec = v; in_mask = m; in_zmask = zm; in_valid = 1'b1;
    @(negedge clk);
    chk(out_vec, model(v, m, zm), req);
    chk({{(VW-1){1'b0}}, out_valid}, {{(VW-1){1'b0}}, 1'b1}, "R7 out_valid high");
  endtask

  function automatic logic [VW-1:0] distinct_vec(input int base);
    logic [VW-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*DW +: DW] = base + k * 7;
    return v;
  endfunction

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [VW-1:0] v;
    logic [VW-1:0] held;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    // R8: reset state
    chk(out_vec, '0, "R8 out_vec in reset");
    chk({{(VW-1){1'b0}}, out_valid}, '0, "R8 out_valid in reset");
    rst = 1'b0;

    // R1: 1,1,1,2 pattern
    v = distinct_vec(100);
    v[0 +: DW] = 1; v[DW +: DW] = 1; v[2*DW +: DW] = 1; v[3*DW +: DW] = 2;
    apply(v, '0, 1'b0, "R1 1112 pattern");
    chk({{(VW-16){1'b0}}, out_vec[DW +: 4], out_vec[2*DW +: 4], out_vec[3*DW +: 4], 4'h0},
        {{(VW-16){1'b0}}, 4'h1, 4'h3, 4'h0, 4'h0}, "R1 1112 lane bits");

    // R10: all equal, all distinct
    v = '0;
    for (int k = 0; k < LANES; k++) v[k*DW +: DW] = 32'hDEAD_BEEF;
    apply(v, '0, 1'b0, "R10 all equal");
    chk({{(VW-DW){1'b0}}, out_vec[15*DW +: DW]}, {{(VW-DW){1'b0}}, 32'h0000_7FFF}, "R10 lane15 all equal");
    apply(distinct_vec(5), '0, 1'b0, "R10 all distinct");

    // R1: values differing only in the top or bottom bit must not match
    v = '0;
    for (int k = 0; k < LANES; k++) v[k*DW +: DW] = (k % 2) ? 32'h8000_0000 : 32'h0000_0000;
    v[3*DW +: DW] = 32'h0000_0001;
    apply(v, '0, 1'b0, "R1 single-bit differences");

    // R4: zero-masking clears unselected lanes
    v = '0;
    apply(v, 16'h00F0, 1'b1, "R4 zero-mask all equal");
    // R5: mask ignored when zero-masking off
    apply(v, 16'h0000, 1'b0, "R5 mask ignored");
    // R6: selected lane matches unselected lower lanes
    apply(v, 16'h8000, 1'b1, "R6 comparison set full");
    chk({{(VW-DW){1'b0}}, out_vec[15*DW +: DW]}, {{(VW-DW){1'b0}}, 32'h0000_7FFF}, "R6 lane15 sees unselected");

    // R9: idle cycles hold the output
    held = out_vec;
    in_valid = 1'b0; in_vec = distinct_vec(9); in_mask = 16'h0000; in_zmask = 1'b1;
    @(negedge clk);
    chk(out_vec, held, "R9 hold while idle");
    chk({{(VW-1){1'b0}}, out_valid}, '0, "R7 out_valid low");
    @(negedge clk);
    chk(out_vec, held, "R9 hold second idle cycle");

    // random, collision rich; R2 and R3 upper bits checked on every vector
    for (int t = 0; t < 400; t++) begin
      logic [15:0] m;
      logic zm;
      for (int k = 0; k < LANES; k++)
        v[k*DW +: DW] = (t % 3 == 0) ? $urandom() : ($urandom() % 4) | (((t % 2) != 0) ? 32'hA500_0000 : 32'h0);
      m  = 16'($urandom());
      zm = 1'($urandom());
      apply(v, m, zm, zm ? "R4 random masked" : "R1 random unmasked");
      for (int k = 0; k < LANES; k++) begin
        logic [DW-1:0] lane;
        lane = out_vec[k*DW +: DW];
        if (k == 0) chk({{(VW-DW){1'b0}}, lane}, '0, "R3 lane0 zero");
        else chk({{(VW-DW){1'b0}}, lane >> k}, '0, "R2 upper bits zero");
      end
      if ((t % 50) == 49) begin
        held = out_vec;
        in_valid = 1'b0; in_vec = ~in_vec;
        @(negedge clk);
        chk(out_vec, held, "R9 random idle hold");
      end
    end

    // R8: reset mid-run clears state
    rst = 1'b1;
    @(negedge clk);
    chk(out_vec, '0, "R8 reset clears output");
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule